// File: doc/BRIEF.md
# Accumulator ALU with 6502-style flags

This is a purely combinational 8-bit arithmetic and logic unit for a small 6502-style processor core. The surrounding datapath hands it an operation code, the accumulator, the X index register, an operand byte and the incoming N, V, Z and C status bits. It answers within the same cycle with a result byte, the four updated status bits and a destination code. The destination code tells the register-write logic whether the byte belongs in the accumulator, in X, back in the operand's location, or nowhere.

A single shared adder serves add, subtract, both compares, increment, decrement and the undocumented masked subtract into X. Subtraction is formed as A + ~operand + C, so the carry out already means "no borrow". A separate logic unit handles AND, OR, exclusive OR and the bit test. A shifter handles the two shifts and the two rotates. Decimal arithmetic, the register file, memory access and instruction decoding are not part of this block. The interrupt-disable and decimal bits never pass through it, so it cannot change them.

Top module: `alu6502_core`

## Requirements
- R1: Code 0 (add) gives result = A + operand + C_in mod 256 and C = bit 8 of the 9-bit sum. V is set when A and the operand share a sign bit and the result sign differs from A. Destination is accumulator (code 1).
- R2: Code 1 (subtract) gives result = A − operand − (1 − C_in) mod 256 and C = 1 exactly when no borrow occurs. V is set when A's sign differs from both the operand's and the result's. Destination is accumulator (code 1).
- R3: Codes 2 (compare with A) and 3 (compare with X) drive result with (reg − operand) mod 256, Z and N from that byte, and C = 1 when reg ≥ operand. V is passed through and the destination is none (code 0).
- R4: Codes 4 (AND), 5 (OR) and 6 (XOR) combine A with the operand, pass V and C through and target the accumulator (code 1).
- R5: Code 7 (bit test) drives result with A AND operand and sets Z when that byte is zero. N and V copy operand bits 7 and 6, C is passed through and the destination is none (code 0).
- R6: Codes 8 (increment) and 9 (decrement) act on the operand modulo 256, change only Z and N, and target the operand location (code 3).
- R7: Codes 10 (shift left) and 12 (rotate left) move operand bit 7 into C. Bit 0 becomes 0 for the shift and C_in for the rotate. V is passed through and the destination is code 3.
- R8: Codes 11 (logical shift right) and 13 (rotate right) move operand bit 0 into C. Bit 7 becomes 0 for the shift, so N is always 0 there, and C_in for the rotate. V is passed through and the destination is code 3.
- R9: Code 14 computes ((A AND X) − operand) mod 256 with Z and N from the byte and C = 1 when (A AND X) ≥ operand. V is passed through and the destination is X (code 2).
- R10: For every operation that updates Z and N other than the bit test, Z is 1 exactly when the result byte is zero and N equals result bit 7.
- R11: Code 15 is reserved: result equals A, all four flags pass through and the destination is none (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (values in R1–R11 above) |
| acc_i | input | 8 | Accumulator value |
| x_i | input | 8 | X index register value |
| opnd_i | input | 8 | Operand byte (memory or immediate) |
| n_i | input | 1 | Incoming negative flag |
| v_i | input | 1 | Incoming overflow flag |
| z_i | input | 1 | Incoming zero flag |
| c_i | input | 1 | Incoming carry flag |
| result_o | output | 8 | Result byte |
| n_o | output | 1 | Updated negative flag |
| v_o | output | 1 | Updated overflow flag |
| z_o | output | 1 | Updated zero flag |
| c_o | output | 1 | Updated carry flag |
| dest_o | output | 2 | Result destination: 0 none, 1 A, 2 X, 3 operand |

## Verification
Every operation code is swept over all 256 operand bytes against the accumulator values 0x00, 0x7F, 0x80 and 0xFF, with both carry-in values. This crosses the signed boundaries that separate true overflow from plain carry, and equal-versus-less compares from their borrow cases. Random operands, X values and incoming flags then show whether untouched flags really pass through, which a sweep with fixed flags cannot reveal. Directed cases pin the wrap of increment from 0xFF and decrement from 0x00, and the rotate carry paths. They also pin a masked subtract whose AND term differs from A, which separates it from a plain compare.

// File: rtl/alu6502_pkg.sv
package alu6502_pkg;
  typedef enum logic [3:0] {
    OP_ADC  = 4'd0,  OP_SBC  = 4'd1,  OP_CMPA = 4'd2,  OP_CMPX = 4'd3,
    OP_AND  = 4'd4,  OP_ORA  = 4'd5,  OP_EOR  = 4'd6,  OP_BIT  = 4'd7,
    OP_INC  = 4'd8,  OP_DEC  = 4'd9,  OP_ASL  = 4'd10, OP_LSR  = 4'd11,
    OP_ROL  = 4'd12, OP_ROR  = 4'd13, OP_AXS  = 4'd14, OP_RSVD = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0, DST_ACC = 2'd1, DST_X = 2'd2, DST_OPND = 2'd3
  } dest_e;

  // low two op bits select these directly
  typedef enum logic [1:0] {
    SH_ROL = 2'd0, SH_ROR = 2'd1, SH_ASL = 2'd2, SH_LSR = 2'd3
  } shift_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0, LG_ORA = 2'd1, LG_EOR = 2'd2, LG_TST = 2'd3
  } logic_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         inv_b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   full;

  assign b_eff  = inv_b_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[MSB:0];
  assign cout_o = full[W];
  assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 8
) (
  input  alu6502_pkg::logic_e sel_i,
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  output logic [W-1:0]        y_o
);
  import alu6502_pkg::*;

  always_comb begin
    unique case (sel_i)
      LG_ORA:  y_o = a_i | b_i;
      LG_EOR:  y_o = a_i ^ b_i;
      default: y_o = a_i & b_i;  // AND and bit test
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 8
) (
  input  alu6502_pkg::shift_e mode_i,
  input  logic [W-1:0]        d_i,
  input  logic                cin_i,
  output logic [W-1:0]        q_o,
  output logic                cout_o
);
  import alu6502_pkg::*;

  localparam int MSB = W - 1;

  logic fill;

  always_comb begin
    fill = (mode_i == SH_ROL || mode_i == SH_ROR) ? cin_i : 1'b0;
    if (mode_i == SH_ROL || mode_i == SH_ASL) begin
      q_o    = {d_i[MSB-1:0], fill};
      cout_o = d_i[MSB];
    end else begin
      q_o    = {fill, d_i[MSB:1]};
      cout_o = d_i[0];
    end
  end
endmodule

// File: rtl/alu6502_core.sv
module alu6502_core #(
  parameter int W = 8
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] opnd_i,
  input  logic         n_i,
  input  logic         v_i,
  input  logic         z_i,
  input  logic         c_i,
  output logic [W-1:0] result_o,
  output logic         n_o,
  output logic         v_o,
  output logic         z_o,
  output logic         c_o,
  output logic [1:0]   dest_o
);
  import alu6502_pkg::*;

  localparam int MSB = W - 1;

  op_e          op;
  logic [W-1:0] add_a, add_b, add_sum;
  logic         add_cin, add_inv, add_cout, add_ovf;
  logic [W-1:0] lg_y, sh_q;
  logic         sh_c;
  logic         upd_zn;
  dest_e        dest;

  assign op = op_e'(op_i);

  always_comb begin
    add_a   = acc_i;
    add_b   = opnd_i;
    add_cin = c_i;
    add_inv = 1'b0;
    unique case (op)
      OP_SBC:  add_inv = 1'b1;
      OP_CMPA: begin add_cin = 1'b1; add_inv = 1'b1; end
      OP_CMPX: begin add_a = x_i; add_cin = 1'b1; add_inv = 1'b1; end
      OP_AXS:  begin add_a = acc_i & x_i; add_cin = 1'b1; add_inv = 1'b1; end
      OP_INC:  begin add_a = opnd_i; add_b = '0; add_cin = 1'b1; end
      OP_DEC:  begin add_a = opnd_i; add_b = '0; add_cin = 1'b0; add_inv = 1'b1; end
      default: ;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a_i    (add_a),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .inv_b_i(add_inv),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .sel_i(logic_e'(op_i[1:0])),
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .y_o  (lg_y)
  );

  alu_shift #(.W(W)) u_shift (
    .mode_i(shift_e'(op_i[1:0])),
    .d_i   (opnd_i),
    .cin_i (c_i),
    .q_o   (sh_q),
    .cout_o(sh_c)
  );

  always_comb begin
    result_o = acc_i;
    n_o      = n_i;
    v_o      = v_i;
    z_o      = z_i;
    c_o      = c_i;
    dest     = DST_NONE;
    upd_zn   = 1'b0;
    unique case (op)
      OP_ADC, OP_SBC: begin
        result_o = add_sum; c_o = add_cout; v_o = add_ovf;
        upd_zn = 1'b1; dest = DST_ACC;
      end
      OP_CMPA, OP_CMPX: begin
        result_o = add_sum; c_o = add_cout; upd_zn = 1'b1;
      end
      OP_AXS: begin
        result_o = add_sum; c_o = add_cout; upd_zn = 1'b1; dest = DST_X;
      end
      OP_AND, OP_ORA, OP_EOR: begin
        result_o = lg_y; upd_zn = 1'b1; dest = DST_ACC;
      end
      OP_BIT: begin
        result_o = lg_y;
        n_o = opnd_i[MSB];
        v_o = opnd_i[MSB-1];
      end
      OP_INC, OP_DEC: begin
        result_o = add_sum; upd_zn = 1'b1; dest = DST_OPND;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        result_o = sh_q; c_o = sh_c; upd_zn = 1'b1; dest = DST_OPND;
      end
      default: ;
    endcase
    if (upd_zn) n_o = result_o[MSB];
    if (upd_zn || op == OP_BIT) z_o = (result_o == '0);
  end

  assign dest_o = dest;
endmodule

// File: rtl/alu6502_core_chk.sv
module alu6502_core_chk #(
  parameter int W = 8
) (
  input logic [3:0]   op_i,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opnd_i,
  input logic         n_i,
  input logic         v_i,
  input logic         z_i,
  input logic         c_i,
  input logic [W-1:0] result_o,
  input logic         n_o,
  input logic         v_o,
  input logic         z_o,
  input logic         c_o,
  input logic [1:0]   dest_o
);
  import alu6502_pkg::*;

  localparam int MSB = W - 1;

  always_comb begin
    if (op_i == OP_BIT) begin
      a_r5_bit_flags: assert (n_o == opnd_i[MSB] && v_o == opnd_i[MSB-1] && c_o == c_i);
    end
    if (op_i == OP_LSR) begin
      a_r8_lsr_n_clear: assert (!n_o && c_o == opnd_i[0]);
    end
    if (op_i == OP_CMPA || op_i == OP_CMPX) begin
      a_r3_cmp_no_store: assert (v_o == v_i && dest_o == DST_NONE);
    end
    if (op_i == OP_INC || op_i == OP_DEC) begin
      a_r6_incdec_keep_vc: assert (v_o == v_i && c_o == c_i && dest_o == DST_OPND);
    end
    if (op_i == OP_AND || op_i == OP_ORA || op_i == OP_EOR) begin
      a_r4_logic_keep_vc: assert (v_o == v_i && c_o == c_i && dest_o == DST_ACC);
    end
    if (op_i == OP_AXS) begin
      a_r9_axs_to_x: assert (dest_o == DST_X && v_o == v_i);
    end
    if (op_i == OP_RSVD) begin
      a_r11_rsvd_pass: assert (result_o == acc_i && n_o == n_i && v_o == v_i &&
                               z_o == z_i && c_o == c_i && dest_o == DST_NONE);
    end
    if (op_i == OP_ASL) begin
      a_r7_asl_carry: assert (c_o == opnd_i[MSB] && !result_o[0]);
    end
  end
endmodule

bind alu6502_core alu6502_core_chk #(.W(W)) u_chk (
  .op_i    (op_i),
  .acc_i   (acc_i),
  .opnd_i  (opnd_i),
  .n_i     (n_i),
  .v_i     (v_i),
  .z_i     (z_i),
  .c_i     (c_i),
  .result_o(result_o),
  .n_o     (n_o),
  .v_o     (v_o),
  .z_o     (z_o),
  .c_o     (c_o),
  .dest_o  (dest_o)
);

// File: tb/alu6502_core_tb.sv
module alu6502_core_tb;
  logic       clk = 1'b0;
  logic [3:0] op;
  logic [7:0] acc, xr, opnd;
  logic       n_i, v_i, z_i, c_i;
  logic [7:0] result;
  logic       n_o, v_o, z_o, c_o;
  logic [1:0] dest;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  alu6502_core u_dut (
    .op_i(op), .acc_i(acc), .x_i(xr), .opnd_i(opnd),
    .n_i(n_i), .v_i(v_i), .z_i(z_i), .c_i(c_i),
    .result_o(result), .n_o(n_o), .v_o(v_o), .z_o(z_o), .c_o(c_o),
    .dest_o(dest)
  );

  function automatic string req_of(int o);
    case (o)
      0: return "R1";  1: return "R2";  2, 3: return "R3";
      4, 5, 6: return "R4";  7: return "R5";  8, 9: return "R6";
      10, 12: return "R7";  11, 13: return "R8";  14: return "R9";
      default: return "R11";
    endcase
  endfunction

  // packed {result[7:0], n, v, z, c, dest[1:0]}
  function automatic logic [13:0] model(int o, int a, int x, int b,
                                        bit ni, bit vi, bit zi, bit ci);
    int r = a; bit n = ni, v = vi, z = zi, c = ci; int d = 0; bit zn = 1;
    int t;
    case (o)
      0: begin t = a + b + ci; r = t & 255; c = t > 255;
               v = ((a < 128) == (b < 128)) && ((r < 128) != (a < 128)); d = 1; end
      1: begin t = a - b - (ci ? 0 : 1); r = t & 255; c = t >= 0;
               v = ((a < 128) != (b < 128)) && ((r < 128) != (a < 128)); d = 1; end
      2: begin t = a - b; r = t & 255; c = t >= 0; end
      3: begin t = x - b; r = t & 255; c = t >= 0; end
      4: begin r = a & b; d = 1; end
      5: begin r = a | b; d = 1; end
      6: begin r = a ^ b; d = 1; end
      7: begin r = a & b; zn = 0; z = (r == 0); n = b[7]; v = b[6]; end
      8: begin r = (b + 1) % 256; d = 3; end
      9: begin r = (b + 255) % 256; d = 3; end
      10: begin r = (b * 2) % 256; c = b >= 128; d = 3; end
      11: begin r = b / 2; c = b[0]; d = 3; end
      12: begin r = (b * 2) % 256 + ci; c = b >= 128; d = 3; end
      13: begin r = b / 2 + (ci ? 128 : 0); c = b[0]; d = 3; end
      14: begin t = (a & x) - b; r = t & 255; c = t >= 0; d = 2; end
      default: zn = 0;
    endcase
    if (zn) begin z = (r == 0); n = r >= 128; end
    return {r[7:0], n, v, z, c, d[1:0]};
  endfunction

  task automatic apply(int o, int a, int x, int b, bit ni, bit vi, bit zi, bit ci,
                       string tag);
    logic [13:0] exp, got;
    @(negedge clk);
    op = o[3:0]; acc = a[7:0]; xr = x[7:0]; opnd = b[7:0];
    n_i = ni; v_i = vi; z_i = zi; c_i = ci;
    #1;
    exp = model(o, a, x, b, ni, vi, zi, ci);
    got = {result, n_o, v_o, z_o, c_o, dest};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h x=%h b=%h ci=%0b: got res=%h nvzc=%b dest=%0d exp res=%h nvzc=%b dest=%0d",
               tag, o, a[7:0], x[7:0], b[7:0], ci, got[13:6], got[5:2], got[1:0],
               exp[13:6], exp[5:2], exp[1:0]);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(1234);
    // all-zero inputs: 0 + 0 gives zero with Z set (R1, R10)
    apply(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // directed corners
    apply(0, 8'h7F, 0, 8'h01, 0, 0, 0, 0, "R1");  // signed overflow
    apply(0, 8'hFF, 0, 8'h01, 0, 0, 0, 0, "R10"); // zero result, carry out
    apply(1, 8'h80, 0, 8'h01, 0, 0, 0, 1, "R2");  // overflow on subtract
    apply(1, 8'h00, 0, 8'h01, 0, 0, 0, 1, "R2");  // borrow clears C
    apply(2, 8'h40, 0, 8'h40, 0, 1, 0, 0, "R3");  // equal, V kept
    apply(3, 0, 8'h10, 8'h20, 0, 0, 0, 1, "R3");
    apply(7, 8'h0F, 0, 8'hC0, 0, 0, 0, 1, "R5");  // zero AND, N V from operand
    apply(8, 0, 0, 8'hFF, 0, 1, 0, 1, "R6");      // wrap up
    apply(9, 0, 0, 8'h00, 0, 0, 1, 0, "R6");      // wrap down
    apply(9, 0, 0, 8'h80, 1, 0, 0, 0, "R10");     // N follows bit 7
    apply(12, 0, 0, 8'h80, 0, 0, 0, 1, "R7");
    apply(13, 0, 0, 8'h01, 0, 0, 0, 1, "R8");
    apply(11, 0, 0, 8'hFF, 1, 0, 0, 0, "R8");
    apply(14, 8'hF0, 8'h3C, 8'h31, 0, 1, 0, 0, "R9"); // 0x30-0x31 borrows
    apply(15, 8'h5A, 8'h11, 8'h22, 1, 0, 1, 0, "R11");
    // sweeps across signed boundaries
    for (int o = 0; o < 16; o++)
      for (int ai = 0; ai < 4; ai++)
        for (int b = 0; b < 256; b++)
          for (int ci = 0; ci < 2; ci++) begin
            int a;
            case (ai) 0: a = 8'h00; 1: a = 8'h7F; 2: a = 8'h80; default: a = 8'hFF; endcase
            apply(o, a, 8'hA5 ^ b, b, b[3], b[5], b[1], ci[0], req_of(o));
          end
    // random operands and incoming flags
    for (int i = 0; i < 6000; i++) begin
      int o, a, x, b;
      logic [3:0] f;
      o = $urandom_range(0, 15);
      a = $urandom_range(0, 255);
      x = $urandom_range(0, 255);
      b = $urandom_range(0, 255);
      f = 4'($urandom_range(0, 15));
      apply(o, a, x, b, f[3], f[2], f[1], f[0], req_of(o));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule